// File: doc/BRIEF.md
# Two-bit bitwise logic sequencer core

This block is a very small processor that runs 8-bit instructions out of a private program store. The store is filled through a write port while the core is held in reset. It is not cleared by reset, so a program survives a restart. After reset is released, the core steps through a fixed four-state cycle for every instruction. The states are fetch, program-counter advance, decode and execute. The four states repeat until reset is asserted again. There is no branching, so the program counter simply counts up and wraps at the end of the store.

Each instruction holds three fields:

- a 4-bit opcode in bits 7..4;
- a first 2-bit operand in bits 3..2;
- a second 2-bit operand in bits 1..0.

The opcode decides how the operands are read. In some opcodes an operand is an immediate value. In others it is a register address. There are three 2-bit registers: A at address 00, B at address 01 and the result register Z at address 10. The logic operations write only Z, and Z cannot be the destination of a store or a copy. Encodings the core does not define, and writes aimed at a register that may not be written, set a sticky error flag and change nothing else.

Top module: `bitlogic_core`

## Requirements
- R1: Register addresses are 00 for A, 01 for B and 10 for Z. A source address of 11 reads as 00.
- R2: Opcodes 0000, 0001, 0010 and 0011 compute NOT, AND, OR and XOR on the two immediate operands, bitwise over 2 bits, and write the result to Z.
- R3: NOT (opcode 0000) computes the inverse of the first operand (bits 3..2) and ignores the second operand.
- R4: Opcodes 0101, 0110 and 0111 compute AND, OR and XOR on the registers addressed by the two operands. They write the result to Z.
- R5: Opcode 0100 writes the first operand, taken as an immediate value, into the register addressed by the second operand. Z is not changed.
- R6: Opcode 1000 copies the register addressed by the first operand into the register addressed by the second operand. Z is not changed.
- R7: A store or copy whose destination is Z (10) or 11 changes no register and sets the error flag.
- R8: Opcodes 1001 through 1111 change no register and set the error flag.
- R9: Once set, the error flag stays high until reset.
- R10: Every instruction takes four clocks. The program counter advances by one in the second clock, before the registers change in the fourth, and it wraps from the last store location to 0.
- R11: Reset clears the program counter, A, B, Z and the error flag, and it leaves the program store intact. Execution starts on the third clock edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| load_en | input | 1 | Write strobe for the program store |
| load_addr | input | ADDR_W | Program store write address |
| load_data | input | 8 | Instruction word to write |
| pc | output | ADDR_W | Program counter |
| reg_a | output | 2 | Register A |
| reg_b | output | 2 | Register B |
| reg_z | output | 2 | Result register Z |
| illegal | output | 1 | Sticky error flag |

## Verification
The program counter sits on the ports, so a phase sequencer that slips or skips a state shows up within one instruction. The counter then advances at the wrong clock relative to the register update. A wrong latched decode shows on the very next execute edge, as the wrong register changing or the flag rising. Because every register is visible and each instruction's outcome is known, a corrupted value is seen at most four clocks after the fault.

// File: rtl/bitlogic_pkg.sv
package bitlogic_pkg;
  localparam int OPC_W   = 4;
  localparam int OPD_W   = 2;
  localparam int DATA_W  = OPD_W;
  localparam int INSTR_W = OPC_W + 2 * OPD_W;

  localparam logic [OPC_W-1:0] OP_NOT   = 4'b0000;
  localparam logic [OPC_W-1:0] OP_AND   = 4'b0001;
  localparam logic [OPC_W-1:0] OP_OR    = 4'b0010;
  localparam logic [OPC_W-1:0] OP_XOR   = 4'b0011;
  localparam logic [OPC_W-1:0] OP_STO   = 4'b0100;
  localparam logic [OPC_W-1:0] OP_ANDR  = 4'b0101;
  localparam logic [OPC_W-1:0] OP_ORR   = 4'b0110;
  localparam logic [OPC_W-1:0] OP_XORR  = 4'b0111;
  localparam logic [OPC_W-1:0] OP_MOV   = 4'b1000;

  localparam logic [OPD_W-1:0] RADDR_A = 2'b00;
  localparam logic [OPD_W-1:0] RADDR_B = 2'b01;
  localparam logic [OPD_W-1:0] RADDR_Z = 2'b10;

  typedef enum logic [1:0] {PH_FETCH, PH_INC, PH_DECODE, PH_EXEC} phase_t;
  typedef enum logic [1:0] {LOP_NOT, LOP_AND, LOP_OR, LOP_XOR} lop_t;

  typedef struct packed {
    logic             is_logic;
    logic             use_regs;
    logic             is_sto;
    logic             is_mov;
    logic             bad;
    lop_t             lop;
    logic [OPD_W-1:0] opd1;
    logic [OPD_W-1:0] opd2;
  } dec_t;

  typedef struct packed {
    logic              wr_a;
    logic              wr_b;
    logic              wr_z;
    logic [DATA_W-1:0] val;
    logic              bad;
  } cmd_t;
endpackage

// File: rtl/bl_reset_sync.sv
module bl_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/bl_prog_rom.sv
module bl_prog_rom #(
  parameter int ADDR_W = 4,
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_addr] <= wr_data;
  end

  assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/bl_decoder.sv
module bl_decoder
  import bitlogic_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output dec_t               dec
);
  logic [OPC_W-1:0] opc;
  logic             dst_ok;

  assign opc    = instr[INSTR_W-1 -: OPC_W];
  assign dst_ok = (instr[OPD_W-1:0] == RADDR_A) || (instr[OPD_W-1:0] == RADDR_B);

  always_comb begin
    dec          = '0;
    dec.opd1     = instr[2*OPD_W-1 -: OPD_W];
    dec.opd2     = instr[OPD_W-1:0];
    dec.lop      = lop_t'(opc[1:0]);
    unique case (opc)
      OP_NOT, OP_AND, OP_OR, OP_XOR: dec.is_logic = 1'b1;
      OP_ANDR, OP_ORR, OP_XORR: begin
        dec.is_logic = 1'b1;
        dec.use_regs = 1'b1;
      end
      OP_STO: begin
        dec.is_sto = dst_ok;
        dec.bad    = !dst_ok;
      end
      OP_MOV: begin
        dec.is_mov   = dst_ok;
        dec.use_regs = 1'b1;
        dec.bad      = !dst_ok;
      end
      default: dec.bad = 1'b1;
    endcase
  end
endmodule

// File: rtl/bl_alu.sv
module bl_alu
  import bitlogic_pkg::*;
(
  input  lop_t              lop,
  input  logic [DATA_W-1:0] x,
  input  logic [DATA_W-1:0] y,
  output logic [DATA_W-1:0] res
);
  always_comb begin
    unique case (lop)
      LOP_NOT: res = ~x;
      LOP_AND: res = x & y;
      LOP_OR:  res = x | y;
      LOP_XOR: res = x ^ y;
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/bl_regfile.sv
module bl_regfile
  import bitlogic_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_a,
  input  logic              wr_b,
  input  logic              wr_z,
  input  logic [DATA_W-1:0] wdata,
  input  logic [OPD_W-1:0]  raddr1,
  input  logic [OPD_W-1:0]  raddr2,
  output logic [DATA_W-1:0] rdata1,
  output logic [DATA_W-1:0] rdata2,
  output logic [DATA_W-1:0] a,
  output logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] z
);
  logic [DATA_W-1:0] a_q, b_q, z_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0;
      b_q <= '0;
      z_q <= '0;
    end else begin
      if (wr_a) a_q <= wdata;
      if (wr_b) b_q <= wdata;
      if (wr_z) z_q <= wdata;
    end
  end

  function automatic logic [DATA_W-1:0] rd(input logic [OPD_W-1:0] ad,
                                           input logic [DATA_W-1:0] va,
                                           input logic [DATA_W-1:0] vb,
                                           input logic [DATA_W-1:0] vz);
    case (ad)
      RADDR_A: rd = va;
      RADDR_B: rd = vb;
      RADDR_Z: rd = vz;
      default: rd = '0;
    endcase
  endfunction

  assign rdata1 = rd(raddr1, a_q, b_q, z_q);
  assign rdata2 = rd(raddr2, a_q, b_q, z_q);
  assign a = a_q;
  assign b = b_q;
  assign z = z_q;
endmodule

// File: rtl/bitlogic_core.sv
module bitlogic_core
  import bitlogic_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_en,
  input  logic [ADDR_W-1:0]  load_addr,
  input  logic [INSTR_W-1:0] load_data,
  output logic [ADDR_W-1:0]  pc,
  output logic [DATA_W-1:0]  reg_a,
  output logic [DATA_W-1:0]  reg_b,
  output logic [DATA_W-1:0]  reg_z,
  output logic               illegal
);
  logic               core_rst_n;
  phase_t             phase_q, phase_d;
  logic [ADDR_W-1:0]  pc_q, pc_d;
  logic [INSTR_W-1:0] ir_q, ir_d, rom_word;
  cmd_t               cmd_q, cmd_d;
  logic               bad_q, bad_d;
  dec_t               dec;
  logic [DATA_W-1:0]  rdata1, rdata2, opx, opy, alu_res;
  logic               in_exec;

  bl_reset_sync #(.STAGES(2)) u_rsync (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(core_rst_n)
  );

  bl_prog_rom #(.ADDR_W(ADDR_W), .WORD_W(INSTR_W)) u_rom (
    .clk(clk), .wr_en(load_en), .wr_addr(load_addr), .wr_data(load_data),
    .rd_addr(pc_q), .rd_data(rom_word)
  );

  bl_decoder u_dec (.instr(ir_q), .dec(dec));

  assign in_exec = (phase_q == PH_EXEC);

  bl_regfile u_rf (
    .clk(clk), .rst_n(core_rst_n),
    .wr_a(in_exec & cmd_q.wr_a), .wr_b(in_exec & cmd_q.wr_b),
    .wr_z(in_exec & cmd_q.wr_z), .wdata(cmd_q.val),
    .raddr1(dec.opd1), .raddr2(dec.opd2),
    .rdata1(rdata1), .rdata2(rdata2),
    .a(reg_a), .b(reg_b), .z(reg_z)
  );

  assign opx = dec.use_regs ? rdata1 : dec.opd1;
  assign opy = dec.use_regs ? rdata2 : dec.opd2;

  bl_alu u_alu (.lop(dec.lop), .x(opx), .y(opy), .res(alu_res));

  always_comb begin
    cmd_d.wr_z = dec.is_logic;
    cmd_d.wr_a = (dec.is_sto | dec.is_mov) && (dec.opd2 == RADDR_A);
    cmd_d.wr_b = (dec.is_sto | dec.is_mov) && (dec.opd2 == RADDR_B);
    cmd_d.bad  = dec.bad;
    if (dec.is_logic)    cmd_d.val = alu_res;
    else if (dec.is_sto) cmd_d.val = dec.opd1;
    else                 cmd_d.val = rdata1;
  end

  always_comb begin
    phase_d = phase_q;
    pc_d    = pc_q;
    ir_d    = ir_q;
    bad_d   = bad_q;
    unique case (phase_q)
      PH_FETCH: begin
        ir_d    = rom_word;
        phase_d = PH_INC;
      end
      PH_INC: begin
        pc_d    = pc_q + 1'b1;
        phase_d = PH_DECODE;
      end
      PH_DECODE: phase_d = PH_EXEC;
      PH_EXEC: begin
        bad_d   = bad_q | cmd_q.bad;
        phase_d = PH_FETCH;
      end
      default: phase_d = PH_FETCH;
    endcase
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      phase_q <= PH_FETCH;
      pc_q    <= '0;
      ir_q    <= '0;
      bad_q   <= 1'b0;
      cmd_q   <= '0;
    end else begin
      phase_q <= phase_d;
      pc_q    <= pc_d;
      ir_q    <= ir_d;
      bad_q   <= bad_d;
      if (phase_q == PH_DECODE) cmd_q <= cmd_d;
    end
  end

  assign pc      = pc_q;
  assign illegal = bad_q;
endmodule

// File: rtl/bitlogic_core_chk.sv
module bitlogic_core_chk
  import bitlogic_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              core_rst_n,
  input phase_t            phase,
  input logic              exec_bad,
  input logic [ADDR_W-1:0] pc,
  input logic [DATA_W-1:0] reg_a,
  input logic [DATA_W-1:0] reg_b,
  input logic [DATA_W-1:0] reg_z,
  input logic              illegal
);
  a_r10_fetch_then_inc: assert property (@(posedge clk) disable iff (!core_rst_n)
    phase == PH_FETCH |=> phase == PH_INC);
  a_r10_exec_then_fetch: assert property (@(posedge clk) disable iff (!core_rst_n)
    phase == PH_EXEC |=> phase == PH_FETCH);
  a_r10_pc_step: assert property (@(posedge clk) disable iff (!core_rst_n)
    phase == PH_INC |=> pc == ADDR_W'($past(pc) + 1'b1));
  a_r10_pc_hold: assert property (@(posedge clk) disable iff (!core_rst_n)
    phase != PH_INC |=> $stable(pc));
  a_r10_regs_exec_only: assert property (@(posedge clk) disable iff (!core_rst_n)
    phase != PH_EXEC |=> $stable(reg_a) && $stable(reg_b) && $stable(reg_z));
  a_r7_bad_no_write: assert property (@(posedge clk) disable iff (!core_rst_n)
    (phase == PH_EXEC && exec_bad) |=>
      $stable(reg_a) && $stable(reg_b) && $stable(reg_z) && illegal);
  a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!core_rst_n)
    illegal |=> illegal);
endmodule

bind bitlogic_core bitlogic_core_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .core_rst_n(core_rst_n), .phase(phase_q), .exec_bad(cmd_q.bad),
  .pc(pc), .reg_a(reg_a), .reg_b(reg_b), .reg_z(reg_z), .illegal(illegal)
);

// File: tb/test_bitlogic_core.sv
module test_bitlogic_core;
  localparam int AW = 4;
  localparam int NPROG = 16;

  // {instruction, A, B, Z, flag} expected after each instruction
  localparam logic [14:0] VEC [0:NPROG-1] = '{
    {8'h0B, 2'd0, 2'd0, 2'd1, 1'b0},  // R3 NOT 10, op2 ignored
    {8'h4C, 2'd3, 2'd0, 2'd1, 1'b0},  // R5 STO 11 -> A
    {8'h49, 2'd3, 2'd2, 2'd1, 1'b0},  // R5 STO 10 -> B
    {8'h1D, 2'd3, 2'd2, 2'd1, 1'b0},  // R2 AND 11,01
    {8'h29, 2'd3, 2'd2, 2'd3, 1'b0},  // R2 OR 10,01
    {8'h3E, 2'd3, 2'd2, 2'd1, 1'b0},  // R2 XOR 11,10
    {8'h51, 2'd3, 2'd2, 2'd2, 1'b0},  // R4 AND A,B
    {8'h72, 2'd3, 2'd2, 2'd1, 1'b0},  // R4 XOR A,Z
    {8'h67, 2'd3, 2'd2, 2'd2, 1'b0},  // R1 OR B,11 (11 reads 0)
    {8'h88, 2'd2, 2'd2, 2'd2, 1'b0},  // R6 MOV Z -> A
    {8'h03, 2'd2, 2'd2, 2'd3, 1'b0},  // R3 NOT 00
    {8'h89, 2'd2, 2'd3, 2'd3, 1'b0},  // R6 MOV Z -> B
    {8'h46, 2'd2, 2'd3, 2'd3, 1'b1},  // R7 STO to Z
    {8'h83, 2'd2, 2'd3, 2'd3, 1'b1},  // R7 MOV to 11
    {8'hB5, 2'd2, 2'd3, 2'd3, 1'b1},  // R8 undefined opcode
    {8'h44, 2'd1, 2'd3, 2'd3, 1'b1}   // R9 flag stays, R5 STO 01 -> A
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic          load_en;
  logic [AW-1:0] load_addr;
  logic [7:0]    load_data;
  logic [AW-1:0] pc;
  logic [1:0]    reg_a, reg_b, reg_z;
  logic          illegal;
  int            n_checks = 0;
  int            n_errors = 0;

  always #10 clk = ~clk;

  bitlogic_core #(.ADDR_W(AW)) i_bitlogic_core (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_addr(load_addr),
    .load_data(load_data), .pc(pc), .reg_a(reg_a), .reg_b(reg_b),
    .reg_z(reg_z), .illegal(illegal)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_state(input string req, input logic [1:0] ea, input logic [1:0] eb,
                             input logic [1:0] ez, input logic ef, input logic [AW-1:0] ep);
    check(req, {reg_a, reg_b, reg_z, illegal, pc}, {ea, eb, ez, ef, ep});
  endtask

  initial begin
    rst_n = 1'b0; load_en = 1'b0; load_addr = '0; load_data = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check_state("R11 reset state", 2'd0, 2'd0, 2'd0, 1'b0, '0);
    for (int i = 0; i < NPROG; i++) begin
      load_en = 1'b1; load_addr = AW'(i); load_data = VEC[i][14:7];
      @(negedge clk);
    end
    load_en = 1'b0;
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check_state("R11 idle two edges after release", 2'd0, 2'd0, 2'd0, 1'b0, '0);
    repeat (2) @(posedge clk);
    for (int k = 0; k < NPROG; k++) begin
      logic [1:0] pa, pb, pz;
      logic       pf;
      if (k == 0) begin pa = 0; pb = 0; pz = 0; pf = 0; end
      else begin pa = VEC[k-1][6:5]; pb = VEC[k-1][4:3]; pz = VEC[k-1][2:1]; pf = VEC[k-1][0]; end
      if (k != 0) repeat (2) @(posedge clk);
      @(negedge clk);
      check_state("R10 pc advanced before execute", pa, pb, pz, pf, AW'(k + 1));
      repeat (2) @(posedge clk);
      @(negedge clk);
      check_state("R1-table vector", VEC[k][6:5], VEC[k][4:3], VEC[k][2:1], VEC[k][0],
                  AW'(k + 1));
    end
    // R10 wrap: instruction 0 runs again, R9 flag still set
    repeat (4) @(posedge clk);
    @(negedge clk);
    check_state("R10 wrap re-executes word 0", 2'd1, 2'd3, 2'd1, 1'b1, AW'(1));
    // R11 asynchronous reset mid-run, store kept
    rst_n = 1'b0;
    #1;
    check_state("R11 async reset clears state", 2'd0, 2'd0, 2'd0, 1'b0, '0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(posedge clk);
    @(negedge clk);
    check_state("R10 before first execute", 2'd0, 2'd0, 2'd0, 1'b0, AW'(1));
    @(posedge clk);
    @(negedge clk);
    check_state("R11 store survives reset R3", 2'd0, 2'd0, 2'd1, 1'b0, AW'(1));
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule